// File: doc/BRIEF.md
# Rank-Sweeping Bit-Serial Sorter

This block sorts a small set of unsigned words in hardware. A run starts with a one-cycle request that carries the set size and the direction. The words are then written in one per accepted clock, and the sorted set comes out one word per clock. The engine selects words by rank, one bit-plane at a time. It does not compare whole words. A rank sequencer issues one rank per cycle, starting at the smallest rank for ascending order or at the largest for descending order. Each rank then walks down a pipeline of bit-plane stages, MSB plane first. So every plane works on a different rank in the same cycle, and the whole set leaves the engine in set-size plus word-width cycles after the last word arrives.

Each stage knows which words are still candidates and how many of them must still be skipped. It counts the candidates that have a zero in its plane. From that count it decides the output bit, narrows the candidate set and passes the reduced rank to the next stage. The decided upper bits travel along with the rank, so each stage fills in one more bit of the result. On the input side, the stored bits of plane j are written j cycles after the word is accepted. This matches the moment when plane j is first read.

Top module: `rank_sweep_sorter`

## Requirements
- R1: While reset is held and in the first cycle after it, `sort_active` and `out_valid` are low.
- R2: A `sort_req` taken while idle raises `sort_active` in the next cycle. It also latches `sort_desc` (1 = descending) and the set size from `win_size`. A `win_size` of 0, or one above NUM_WORDS, is taken as NUM_WORDS.
- R3: While a run is loading, each cycle with `in_valid` high stores one word, until the set size is reached. Cycles with `in_valid` low are skipped. `in_valid` has no effect while idle or while sorting.
- R4: With `sort_desc` = 0, the output words come out in non-decreasing order and form exactly the loaded set.
- R5: With `sort_desc` = 1, the output words come out in non-increasing order and form exactly the loaded set.
- R6: Equal values are all kept: a value loaded k times appears k times at the output.
- R7: `out_valid` first rises exactly WORD_W clock edges after the edge that stores the last word. It then stays high for set-size consecutive cycles, with one word per cycle.
- R8: `out_valid` is high only while `sort_active` is high. `sort_active` falls at the same edge at which `out_valid` falls after the last word.
- R9: A `sort_req` that arrives while `sort_active` is high has no effect on the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| sort_req | input | 1 | One-cycle request that starts a run |
| sort_desc | input | 1 | Direction for the run: 0 ascending, 1 descending |
| win_size | input | $clog2(NUM_WORDS+1) | Number of words in the run |
| in_valid | input | 1 | Input word strobe during loading |
| in_data | input | WORD_W | Unsigned input word |
| sort_active | output | 1 | High from the request until the last sorted word has left |
| out_valid | output | 1 | Marks a sorted word on `out_data` |
| out_data | output | WORD_W | Sorted output word |

## Verification
The bench sweeps every `win_size` code, both directions and four data patterns on a 5-word, 3-bit configuration:
- **All-equal set.** It isolates the duplicate handling of the rank-residual update.
- **Two scrambled linear sequences.** They separate ascending from descending selection on distinct values.
- **Set with repeated small values.** It mixes duplicates with distinct words, so that rank residuals cross a group of equal words.

Some runs insert idle cycles between input words and raise a stray request during them. Every run also drives junk input and requests while sorting. These show that the latency counts from the last stored word, and that nothing outside the load window reaches the stored set. Sizes 0, 6 and 7 show the clamp to the full set, and size 1 shows the degenerate single-word run.

// File: rtl/rs_sort_pkg.sv
// Package rs_sort_pkg
// Shared types for the rank-sweeping sorter. Holds the run-control state
// encoding used by the top level.
package rs_sort_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_SORT = 2'd2
    } rs_state_e;

endpackage

// File: rtl/rs_plane_store.sv
// Module rs_plane_store
// Holds one bit-plane of the stored word set: bit `plane[i]` belongs to word i.
// The write strobe, index and bit are delayed by DELAY cycles first, so the
// plane is filled exactly when the rank pipeline first reads it.
// Assumes wr_idx < NUM_WORDS whenever wr_en is high.
module rs_plane_store #(
    parameter int NUM_WORDS = 8,
    parameter int DELAY     = 0,
    parameter int IW        = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [IW-1:0]        wr_idx,
    input  logic                 wr_bit,
    output logic [NUM_WORDS-1:0] plane
);

    logic          d_en;
    logic [IW-1:0] d_idx;
    logic          d_bit;

    generate
        if (DELAY == 0) begin : g_nodelay
            assign d_en  = wr_en;
            assign d_idx = wr_idx;
            assign d_bit = wr_bit;
        end else begin : g_delay
            logic [DELAY-1:0] en_sr;
            logic [DELAY-1:0] bit_sr;
            logic [IW-1:0]    idx_sr [DELAY];

            // Skew chain: shift the write strobe, index and bit by one stage.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    en_sr <= '0;
                end else begin
                    for (int s = DELAY - 1; s > 0; s--) begin
                        en_sr[s] <= en_sr[s-1];
                    end
                    en_sr[0] <= wr_en;
                end
                for (int s = DELAY - 1; s > 0; s--) begin
                    bit_sr[s] <= bit_sr[s-1];
                    idx_sr[s] <= idx_sr[s-1];
                end
                bit_sr[0] <= wr_bit;
                idx_sr[0] <= wr_idx;
            end

            assign d_en  = en_sr[DELAY-1];
            assign d_idx = idx_sr[DELAY-1];
            assign d_bit = bit_sr[DELAY-1];
        end
    endgenerate

    // Storage: write the delayed bit into its word position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            plane <= '0;
        end else if (d_en) begin
            plane[d_idx] <= d_bit;
        end
    end

endmodule

// File: rtl/rs_rank_seq.sv
// Module rs_rank_seq
// Issues one rank per cycle for a run of `cnt` words. Ascending runs count
// up from 0 and descending runs count down from cnt-1. `last` marks the final
// rank. Assumes cnt >= 1 and that desc is stable for the whole run.
module rs_rank_seq #(
    parameter int NUM_WORDS = 8,
    parameter int CW        = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] cnt,
    input  logic          desc,
    output logic          v,
    output logic [CW-1:0] k,
    output logic          last
);

    logic [CW-1:0] remain;

    // Rank counter: load the first rank on start, then step toward the last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v      <= 1'b0;
            k      <= '0;
            remain <= '0;
        end else if (start) begin
            v      <= 1'b1;
            k      <= desc ? cnt - 1'b1 : '0;
            remain <= cnt - 1'b1;
        end else if (v) begin
            if (remain == '0) begin
                v <= 1'b0;
            end else begin
                k      <= desc ? k - 1'b1 : k + 1'b1;
                remain <= remain - 1'b1;
            end
        end
    end

    assign last = v && (remain == '0);

    // Consecutive ranks in one ascending run differ by exactly one (R4).
    p_rank_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
        v && $past(v) && !desc && !$past(start) |-> k == $past(k) + 1'b1);

    // Consecutive ranks in one descending run differ by exactly minus one (R5).
    p_rank_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
        v && $past(v) && desc && !$past(start) |-> k == $past(k) - 1'b1);

    // A rank never reaches the set size (R7).
    p_rank_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        v |-> k < cnt);

endmodule

// File: rtl/rs_plane_stage.sv
// Module rs_plane_stage
// One bit-plane stage of the rank pipeline. It counts the candidate words
// that have a zero in this plane. If the rank residual is below that count,
// the output bit is 0 and the zero-bit words stay candidates. Otherwise the
// bit is 1, the ones stay candidates and the residual is reduced by the
// count. The decided bit is written at BITPOS of the word carried along.
// Assumes the residual is below the number of candidates on entry.
module rs_plane_stage #(
    parameter int NUM_WORDS = 8,
    parameter int WORD_W    = 8,
    parameter int CW        = 4,
    parameter int BITPOS    = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 v_in,
    input  logic [CW-1:0]        k_in,
    input  logic [NUM_WORDS-1:0] mask_in,
    input  logic [WORD_W-1:0]    word_in,
    input  logic                 last_in,
    input  logic [NUM_WORDS-1:0] plane,
    output logic                 v_out,
    output logic [CW-1:0]        k_out,
    output logic [NUM_WORDS-1:0] mask_out,
    output logic [WORD_W-1:0]    word_out,
    output logic                 last_out
);

    logic [NUM_WORDS-1:0] zero_cand;
    logic [CW-1:0]        zeros;
    logic                 bit_one;
    logic [WORD_W-1:0]    word_nxt;

    // Zero count: candidates that have a 0 in this plane.
    always_comb begin
        zero_cand = mask_in & ~plane;
        zeros     = '0;
        for (int i = 0; i < NUM_WORDS; i++) begin
            zeros = zeros + CW'(zero_cand[i]);
        end
    end

    // Bit decision and insertion of the bit into the carried word.
    always_comb begin
        bit_one          = (k_in >= zeros);
        word_nxt         = word_in;
        word_nxt[BITPOS] = bit_one;
    end

    // Stage register: pass the narrowed rank state to the next plane.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_out    <= 1'b0;
            last_out <= 1'b0;
        end else begin
            v_out    <= v_in;
            last_out <= v_in && last_in;
        end
        k_out    <= bit_one ? k_in - zeros : k_in;
        mask_out <= bit_one ? (mask_in & plane) : zero_cand;
        word_out <= word_nxt;
    end

    // At least one word stays a candidate, so duplicates are never lost (R6).
    p_candidate_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        v_out |-> mask_out != '0);

endmodule

// File: rtl/rank_sweep_sorter.sv
// Module rank_sweep_sorter (top)
// Sorts a set of up to NUM_WORDS unsigned WORD_W-bit words.
// - A request latches the set size and the direction.
// - The words are stored one per strobed cycle into skewed bit-plane stores.
// - A rank sequencer then feeds one rank per cycle into a WORD_W-stage
//   bit-plane pipeline, which yields one sorted word per cycle.
// Assumes sort_req is a single-cycle pulse, and that input words arrive only
// after the request.
module rank_sweep_sorter
    import rs_sort_pkg::*;
#(
    parameter int NUM_WORDS = 8,
    parameter int WORD_W    = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              sort_req,
    input  logic                              sort_desc,
    input  logic [$clog2(NUM_WORDS+1)-1:0]    win_size,
    input  logic                              in_valid,
    input  logic [WORD_W-1:0]                 in_data,
    output logic                              sort_active,
    output logic                              out_valid,
    output logic [WORD_W-1:0]                 out_data
);

    localparam int CW = $clog2(NUM_WORDS + 1);
    localparam int IW = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

    rs_state_e            state;
    logic [CW-1:0]        cnt_q;
    logic                 desc_q;
    logic [CW-1:0]        load_idx;
    logic [CW-1:0]        eff_cnt;
    logic                 accept;
    logic                 last_accept;
    logic [NUM_WORDS-1:0] win_mask;

    logic                 st_v    [WORD_W+1];
    logic [CW-1:0]        st_k    [WORD_W+1];
    logic [NUM_WORDS-1:0] st_mask [WORD_W+1];
    logic [WORD_W-1:0]    st_word [WORD_W+1];
    logic                 st_last [WORD_W+1];
    logic [NUM_WORDS-1:0] planes  [WORD_W];

    // Size clamp: zero or oversize requests mean the full set.
    always_comb begin
        if (win_size == '0 || win_size > CW'(NUM_WORDS)) begin
            eff_cnt = CW'(NUM_WORDS);
        end else begin
            eff_cnt = win_size;
        end
    end

    assign accept      = (state == ST_LOAD) && in_valid;
    assign last_accept = accept && (load_idx == cnt_q - 1'b1);

    // Run control: idle -> load -> sort -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt_q    <= '0;
            desc_q   <= 1'b0;
            load_idx <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (sort_req) begin
                        state    <= ST_LOAD;
                        cnt_q    <= eff_cnt;
                        desc_q   <= sort_desc;
                        load_idx <= '0;
                    end
                end
                ST_LOAD: begin
                    if (last_accept) begin
                        state <= ST_SORT;
                    end else if (accept) begin
                        load_idx <= load_idx + 1'b1;
                    end
                end
                ST_SORT: begin
                    if (st_v[WORD_W] && st_last[WORD_W]) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign sort_active = (state != ST_IDLE);

    // Window mask: words inside the requested set start as candidates.
    always_comb begin
        for (int i = 0; i < NUM_WORDS; i++) begin
            win_mask[i] = (CW'(i) < cnt_q);
        end
    end

    // Plane j holds bit WORD_W-1-j of each word and is written j cycles late.
    generate
        for (genvar j = 0; j < WORD_W; j++) begin : g_store
            rs_plane_store #(
                .NUM_WORDS (NUM_WORDS),
                .DELAY     (j),
                .IW        (IW)
            ) u_store (
                .clk    (clk),
                .rst_n  (rst_n),
                .wr_en  (accept),
                .wr_idx (load_idx[IW-1:0]),
                .wr_bit (in_data[WORD_W-1-j]),
                .plane  (planes[j])
            );
        end
    endgenerate

    rs_rank_seq #(
        .NUM_WORDS (NUM_WORDS),
        .CW        (CW)
    ) u_rank (
        .clk   (clk),
        .rst_n (rst_n),
        .start (last_accept),
        .cnt   (cnt_q),
        .desc  (desc_q),
        .v     (st_v[0]),
        .k     (st_k[0]),
        .last  (st_last[0])
    );

    assign st_mask[0] = win_mask;
    assign st_word[0] = '0;

    // Rank pipeline: stage j decides bit WORD_W-1-j from plane j.
    generate
        for (genvar j = 0; j < WORD_W; j++) begin : g_stage
            rs_plane_stage #(
                .NUM_WORDS (NUM_WORDS),
                .WORD_W    (WORD_W),
                .CW        (CW),
                .BITPOS    (WORD_W - 1 - j)
            ) u_stage (
                .clk      (clk),
                .rst_n    (rst_n),
                .v_in     (st_v[j]),
                .k_in     (st_k[j]),
                .mask_in  (st_mask[j]),
                .word_in  (st_word[j]),
                .last_in  (st_last[j]),
                .plane    (planes[j]),
                .v_out    (st_v[j+1]),
                .k_out    (st_k[j+1]),
                .mask_out (st_mask[j+1]),
                .word_out (st_word[j+1]),
                .last_out (st_last[j+1])
            );
        end
    endgenerate

    assign out_valid = st_v[WORD_W];
    assign out_data  = st_word[WORD_W];

    // Output words only appear inside an active run (R8).
    p_valid_in_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> sort_active);

    // Ascending runs never step down (R4).
    p_asc_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && $past(out_valid) && !desc_q |-> out_data >= $past(out_data));

    // Descending runs never step up (R5).
    p_desc_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && $past(out_valid) && desc_q |-> out_data <= $past(out_data));

    // A request during a run leaves the latched size and direction alone (R9).
    p_req_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sort_active && sort_req |=> $stable(cnt_q) && $stable(desc_q));

    // Loading never writes past the latched set size (R3).
    p_load_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_LOAD |-> load_idx < cnt_q);

endmodule

// File: tb/rank_sweep_sorter_test.sv
module rank_sweep_sorter_test;

    localparam int M  = 5;
    localparam int N  = 3;
    localparam int CW = $clog2(M + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sort_req = 1'b0;
    logic          sort_desc = 1'b0;
    logic [CW-1:0] win_size = '0;
    logic          in_valid = 1'b0;
    logic [N-1:0]  in_data = '0;
    logic          sort_active;
    logic          out_valid;
    logic [N-1:0]  out_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    rank_sweep_sorter #(.NUM_WORDS(M), .WORD_W(N)) uut (
        .clk(clk), .rst_n(rst_n), .sort_req(sort_req), .sort_desc(sort_desc),
        .win_size(win_size), .in_valid(in_valid), .in_data(in_data),
        .sort_active(sort_active), .out_valid(out_valid), .out_data(out_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int pattern(input int seed, input int i);
        case (seed)
            0:       return 5;
            1:       return (i * 3 + 1) % 8;
            2:       return (i % 3) * 2;
            default: return (i * 5 + 2) % 8;
        endcase
    endfunction

    task automatic run(input int w, input bit d, input int seed);
        int eff;
        int exp [M];
        int tmp;
        string oreq;
        eff  = (w == 0 || w > M) ? M : w;
        oreq = d ? "R5" : "R4";
        for (int i = 0; i < eff; i++) exp[i] = pattern(seed, i);
        for (int i = 1; i < eff; i++)
            for (int j = i; j > 0; j--)
                if ((!d && exp[j] < exp[j-1]) || (d && exp[j] > exp[j-1])) begin
                    tmp = exp[j]; exp[j] = exp[j-1]; exp[j-1] = tmp;
                end
        @(negedge clk);
        sort_req = 1'b1; sort_desc = d; win_size = CW'(w);
        @(negedge clk);
        sort_req = 1'b0;
        chk(sort_active == 1'b1, "R2", int'(sort_active), 1);
        for (int i = 0; i < eff; i++) begin
            if (seed % 2 == 1) begin
                // R3 idle gap, with a stray request that R9 says is ignored
                in_valid = 1'b0; in_data = 3'd7;
                sort_req = 1'b1; win_size = CW'(1); sort_desc = ~d;
                @(negedge clk);
                sort_req = 1'b0;
            end
            in_valid = 1'b1; in_data = N'(pattern(seed, i));
            @(negedge clk);
        end
        // junk input and request during sorting: R3 and R9 say no effect
        in_valid = 1'b1; in_data = 3'd3; sort_req = 1'b1; win_size = CW'(1);
        for (int c = 1; c <= N; c++) begin
            @(negedge clk);
            chk(out_valid == (c == N), "R7", int'(out_valid), int'(c == N));
        end
        for (int i = 0; i < eff; i++) begin
            if (i > 0) @(negedge clk);
            chk(out_valid == 1'b1, "R7", int'(out_valid), 1);
            chk(int'(out_data) == exp[i], seed == 0 || seed == 2 ? "R6" : oreq,
                int'(out_data), exp[i]);
            chk(sort_active == 1'b1, "R8", int'(sort_active), 1);
        end
        @(negedge clk);
        chk(out_valid == 1'b0, "R7", int'(out_valid), 0);
        chk(sort_active == 1'b0, "R8", int'(sort_active), 0);
        in_valid = 1'b0; sort_req = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(sort_active == 1'b0, "R1", int'(sort_active), 0);
        chk(out_valid == 1'b0, "R1", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sort_active == 1'b0, "R1", int'(sort_active), 0);
        chk(out_valid == 1'b0, "R1", int'(out_valid), 0);
        // R3: strobed words while idle must not start or disturb anything
        in_valid = 1'b1; in_data = 3'd6;
        repeat (3) @(negedge clk);
        chk(sort_active == 1'b0, "R3", int'(sort_active), 0);
        in_valid = 1'b0;
        for (int w = 0; w < (1 << CW); w++)
            for (int d = 0; d < 2; d++)
                for (int s = 0; s < 4; s++)
                    run(w, d[0], s);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule